// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked table of 8-byte region descriptors in memory and turns each one into a transfer segment for a downstream data mover. Software or a command engine writes the address of the first descriptor and the byte count the command is supposed to move, then pulses `start`. The walker reads each descriptor through a single-outstanding 32-bit read port. It hands the segment (buffer address, byte length, flag byte) to the mover and waits for the mover to report that the segment has finished. Only then does it fetch the next descriptor, which sits 8 bytes further on.

Each descriptor is two little-endian words. The first word is the buffer address. In the second word, bits [15:0] hold the byte length, bits [23:16] are unused, and bits [31:24] hold the flags. The walk ends normally after the descriptor carrying the end mark has completed. At that point the block compares the sum of the segment lengths with the expected count and reports a shortfall or an excess. A descriptor with an illegal length, a packet-command descriptor that is not the first in the chain, or a chain that runs past the configured depth ends the walk early with a specific error.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor at byte address P is read as two 32-bit requests, to P and then to P+4. The next descriptor is at P+8. No read request is raised between a segment's handshake and the `seg_done` that completes it.
- R2: The segment offered on the output takes its address from word 0, its length from word 1 bits [15:0] and its flags from word 1 bits [31:24]. The flag bits are: bit 1 drain, bit 2 packet command, bit 3 direct interrupt, bit 4 DMA method, bit 5 write direction, bit 6 io/memory, bit 7 end of chain.
- R3: After the `seg_done` of a descriptor with flag bit 7 set, `done` pulses for one cycle with `busy` low. A new `start` is accepted in that same cycle.
- R4: `total_bytes` equals the sum of the lengths of all segments completed in the walk. It holds its value until the next accepted start.
- R5: On a normal finish, `underflow` is set when the total is below `expect_len`.
- R6: On a normal finish, `overflow` is set when the total exceeds `expect_len` and no descriptor of the walk had the drain flag (bit 1). With drain seen, the excess raises no flag.
- R7: A descriptor with the packet-command flag (bit 2) is offered with the write flag (bit 5) forced on. If such a descriptor is not the first of the chain, the walk aborts with `err_cdb_order`, and that descriptor produces no segment.
- R8: A descriptor whose length field is 0 aborts the walk with `err_zero_len` and produces no segment.
- R9: A length above MAX_SEG_LEN (65024 by default) aborts the walk with `err_seg_long` and produces no segment. A length of exactly 65024 is accepted.
- R10: If MAX_DESC descriptors complete without an end mark, the walk aborts with `err_chain_long`.
- R11: A `start` pulse while `busy` is high is ignored. The running walk continues with its original pointer and results.
- R12: After reset, `busy`, `done`, `mem_req_valid`, `seg_valid` and every result flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_ptr | input | 32 | Byte address of the first descriptor |
| expect_len | input | 32 | Byte count the command should move |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| total_bytes | output | 32 | Sum of completed segment lengths |
| underflow | output | 1 | Total below expected count |
| overflow | output | 1 | Total above expected count, no drain |
| err_zero_len | output | 1 | Walk aborted on zero length |
| err_seg_long | output | 1 | Walk aborted on oversize length |
| err_cdb_order | output | 1 | Walk aborted on misplaced packet-command descriptor |
| err_chain_long | output | 1 | Walk aborted on chain depth |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 16 | Segment byte length |
| seg_flags | output | 8 | Segment flag byte |
| seg_done | input | 1 | Accepted segment has finished |

## Verification
Two events can share a cycle: the `done` pulse that closes one walk, and a `start` that opens the next. The bench raises `start` in the very cycle `done` is seen. It checks the finished walk's totals and flags in that cycle. In the following cycle it checks that `done` has dropped and `busy` has risen, and that the fetch addresses of the new walk match its own pointer. A second pairing is a `start` pulse in the middle of a walk. For that case, the reference model's expected fetch-address queue shows any stray read at the poked pointer.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    // Flag byte bit positions (decoded by the mover and by the walker).
    localparam int FLB_DRAIN  = 1;
    localparam int FLB_CMDPKT = 2;
    localparam int FLB_DIRQ   = 3;
    localparam int FLB_DMA    = 4;
    localparam int FLB_WRITE  = 5;
    localparam int FLB_IOM    = 6;
    localparam int FLB_LAST   = 7;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_REQ_LO,
        WS_WAIT_LO,
        WS_REQ_HI,
        WS_WAIT_HI,
        WS_OFFER,
        WS_XFER,
        WS_CLOSE
    } walk_state_e;

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  flags;
        logic        zero_len;
        logic        too_long;
        logic        cmd_late;
    } desc_view_t;

endpackage

// File: rtl/sgw_desc_check.sv
module sgw_desc_check
    import sgw_pkg::*;
#(
    parameter int unsigned MAX_SEG_LEN = 65024
) (
    input  logic [31:0] hi_word,
    input  logic        is_first,
    output desc_view_t  view
);
    logic [7:0] raw_flags;

    always_comb begin
        raw_flags          = hi_word[31:24];
        view.len           = hi_word[15:0];
        view.flags         = raw_flags;
        // packet-command pointers always move toward the device
        if (raw_flags[FLB_CMDPKT]) begin
            view.flags[FLB_WRITE] = 1'b1;
        end
        view.zero_len      = (hi_word[15:0] == 16'd0);
        view.too_long      = (32'(hi_word[15:0]) > 32'(MAX_SEG_LEN));
        view.cmd_late      = raw_flags[FLB_CMDPKT] && !is_first;
    end
endmodule

// File: rtl/sgw_len_tally.sv
module sgw_len_tally #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [15:0]      add_len,
    input  logic             drain_hit,
    input  logic [TOT_W-1:0] expect_len,
    output logic [TOT_W-1:0] total,
    output logic             short_fall,
    output logic             excess
);
    typedef struct packed {
        logic [TOT_W-1:0] sum;
        logic             drain_seen;
    } tally_t;

    tally_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.sum        = '0;
            d.drain_seen = 1'b0;
        end else begin
            if (add_en) begin
                d.sum = q.sum + TOT_W'(add_len);
            end
            if (drain_hit) begin
                d.drain_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign total      = q.sum;
    assign short_fall = (q.sum < expect_len);
    assign excess     = (q.sum > expect_len) && !q.drain_seen;
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int unsigned MAX_SEG_LEN = 65024,
    parameter int          MAX_DESC    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] base_ptr,
    input  logic [31:0] expect_len,
    output logic        busy,
    output logic        done,
    output logic [31:0] total_bytes,
    output logic        underflow,
    output logic        overflow,
    output logic        err_zero_len,
    output logic        err_seg_long,
    output logic        err_cdb_order,
    output logic        err_chain_long,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        seg_valid,
    input  logic        seg_ready,
    output logic [31:0] seg_addr,
    output logic [15:0] seg_len,
    output logic [7:0]  seg_flags,
    input  logic        seg_done
);
    localparam int IDX_W = $clog2(MAX_DESC + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_DESC - 1);
    localparam logic [31:0] DESC_BYTES = 32'd8;
    localparam logic [31:0] HI_OFFSET  = 32'd4;

    typedef struct packed {
        walk_state_e      state;
        logic [31:0]      ptr;
        logic [IDX_W-1:0] idx;
        logic [31:0]      s_addr;
        logic [15:0]      s_len;
        logic [7:0]       s_flags;
        logic             e_zero;
        logic             e_long;
        logic             e_cmd;
        logic             e_chain;
        logic             under;
        logic             over;
        logic             done;
    } walk_t;

    walk_t q, d;

    desc_view_t view;
    logic       tally_clear;
    logic       tally_add;
    logic       tally_drain;
    logic       tally_short;
    logic       tally_excess;

    sgw_desc_check #(
        .MAX_SEG_LEN(MAX_SEG_LEN)
    ) u_check (
        .hi_word (mem_rsp_data),
        .is_first(q.idx == '0),
        .view    (view)
    );

    sgw_len_tally #(
        .TOT_W(32)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tally_clear),
        .add_en    (tally_add),
        .add_len   (q.s_len),
        .drain_hit (tally_drain),
        .expect_len(expect_len),
        .total     (total_bytes),
        .short_fall(tally_short),
        .excess    (tally_excess)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        tally_clear = 1'b0;
        tally_add   = 1'b0;
        tally_drain = 1'b0;

        unique case (q.state)
            WS_IDLE: begin
                if (start) begin
                    d.state     = WS_REQ_LO;
                    d.ptr       = base_ptr;
                    d.idx       = '0;
                    d.e_zero    = 1'b0;
                    d.e_long    = 1'b0;
                    d.e_cmd     = 1'b0;
                    d.e_chain   = 1'b0;
                    d.under     = 1'b0;
                    d.over      = 1'b0;
                    tally_clear = 1'b1;
                end
            end
            WS_REQ_LO: begin
                if (mem_req_ready) begin
                    d.state = WS_WAIT_LO;
                end
            end
            WS_WAIT_LO: begin
                if (mem_rsp_valid) begin
                    d.s_addr = mem_rsp_data;
                    d.state  = WS_REQ_HI;
                end
            end
            WS_REQ_HI: begin
                if (mem_req_ready) begin
                    d.state = WS_WAIT_HI;
                end
            end
            WS_WAIT_HI: begin
                if (mem_rsp_valid) begin
                    if (view.zero_len) begin
                        d.e_zero = 1'b1;
                        d.done   = 1'b1;
                        d.state  = WS_IDLE;
                    end else if (view.too_long) begin
                        d.e_long = 1'b1;
                        d.done   = 1'b1;
                        d.state  = WS_IDLE;
                    end else if (view.cmd_late) begin
                        d.e_cmd  = 1'b1;
                        d.done   = 1'b1;
                        d.state  = WS_IDLE;
                    end else begin
                        d.s_len     = view.len;
                        d.s_flags   = view.flags;
                        tally_drain = view.flags[FLB_DRAIN];
                        d.state     = WS_OFFER;
                    end
                end
            end
            WS_OFFER: begin
                if (seg_ready) begin
                    d.state = WS_XFER;
                end
            end
            WS_XFER: begin
                if (seg_done) begin
                    tally_add = 1'b1;
                    if (q.s_flags[FLB_LAST]) begin
                        d.state = WS_CLOSE;
                    end else if (q.idx == IDX_LAST) begin
                        d.e_chain = 1'b1;
                        d.done    = 1'b1;
                        d.state   = WS_IDLE;
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.ptr   = q.ptr + DESC_BYTES;
                        d.state = WS_REQ_LO;
                    end
                end
            end
            WS_CLOSE: begin
                d.under = tally_short;
                d.over  = tally_excess;
                d.done  = 1'b1;
                d.state = WS_IDLE;
            end
            default: begin
                d.state = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= WS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy           = (q.state != WS_IDLE);
    assign done           = q.done;
    assign underflow      = q.under;
    assign overflow       = q.over;
    assign err_zero_len   = q.e_zero;
    assign err_seg_long   = q.e_long;
    assign err_cdb_order  = q.e_cmd;
    assign err_chain_long = q.e_chain;

    assign mem_req_valid  = (q.state == WS_REQ_LO) || (q.state == WS_REQ_HI);
    assign mem_req_addr   = (q.state == WS_REQ_HI) ? (q.ptr + HI_OFFSET) : q.ptr;

    assign seg_valid      = (q.state == WS_OFFER);
    assign seg_addr       = q.s_addr;
    assign seg_len        = q.s_len;
    assign seg_flags      = q.s_flags;
endmodule

// File: rtl/sg_chain_walker_chk.sv
module sg_chain_walker_chk #(
    parameter int unsigned MAX_SEG_LEN = 65024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        underflow,
    input logic        overflow,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        seg_valid,
    input logic        seg_ready,
    input logic [31:0] seg_addr,
    input logic [15:0] seg_len,
    input logic [7:0]  seg_flags
);
    // R1: reads and segments never overlap
    a_r1_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && seg_valid));

    // R1: a stalled read keeps its address
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2: a stalled segment keeps its fields
    a_r2_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=>
        (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_flags)));

    // R3: the end pulse is single and arrives idle
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5 and R6: shortfall and excess are exclusive
    a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(underflow && overflow));

    // R7: packet-command segments are outbound
    a_r7_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_flags[2]) |-> seg_flags[5]);

    // R8: no zero-length segment reaches the mover
    a_r8_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != 16'd0));

    // R9: no oversize segment reaches the mover
    a_r9_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (32'(seg_len) <= 32'(MAX_SEG_LEN)));

    // R12: idle block drives no handshake
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !seg_valid));
endmodule

bind sg_chain_walker sg_chain_walker_chk #(
    .MAX_SEG_LEN(MAX_SEG_LEN)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .underflow    (underflow),
    .overflow     (overflow),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr     (seg_addr),
    .seg_len      (seg_len),
    .seg_flags    (seg_flags)
);

// File: tb/sg_chain_walker_tb_top.sv
module sg_chain_walker_tb_top;
    localparam int MAXD   = 8;
    localparam int MAXSEG = 65024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_ptr = '0;
    logic [31:0] expect_len = '0;
    logic        busy, done, underflow, overflow;
    logic        err_zero_len, err_seg_long, err_cdb_order, err_chain_long;
    logic [31:0] total_bytes;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [15:0] seg_len;
    logic [7:0]  seg_flags;
    logic        seg_done = 1'b0;

    always #2 clk = ~clk;

    sg_chain_walker #(
        .MAX_SEG_LEN(MAXSEG),
        .MAX_DESC   (MAXD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_ptr(base_ptr),
        .expect_len(expect_len), .busy(busy), .done(done),
        .total_bytes(total_bytes), .underflow(underflow), .overflow(overflow),
        .err_zero_len(err_zero_len), .err_seg_long(err_seg_long),
        .err_cdb_order(err_cdb_order), .err_chain_long(err_chain_long),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_flags(seg_flags),
        .seg_done(seg_done)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    int  mem_lat = 1;
    int  seg_lat = 1;
    bit  stall = 0;

    typedef struct { logic [31:0] a; logic [15:0] l; logic [7:0] f; } seg_t;
    logic [31:0] q_fetch [$];
    seg_t        q_seg [$];
    logic [31:0] x_total;
    bit x_under, x_over, x_zero, x_long, x_cmd, x_chain;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int byte_at, input logic [31:0] a,
                            input logic [15:0] l, input logic [7:0] f);
        mem[(byte_at >> 2) & 255]       = a;
        mem[((byte_at >> 2) + 1) & 255] = {f, 8'h00, l};
    endtask

    // behavioural reference: walks the table the way the requirements say
    task automatic predict(input logic [31:0] ptr, input logic [31:0] exp_len);
        logic [31:0] p = ptr;
        longint tot = 0;
        bit drain = 0;
        x_under = 0; x_over = 0; x_zero = 0; x_long = 0; x_cmd = 0; x_chain = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] w0, w1;
            seg_t s;
            w0 = mem[(p >> 2) & 255];
            w1 = mem[((p >> 2) + 1) & 255];
            q_fetch.push_back(p);
            q_fetch.push_back(p + 4);
            if (w1[15:0] == 0) begin x_zero = 1; break; end
            if (int'(w1[15:0]) > MAXSEG) begin x_long = 1; break; end
            if (w1[26] && i > 0) begin x_cmd = 1; break; end
            s.a = w0; s.l = w1[15:0]; s.f = w1[31:24];
            if (w1[26]) s.f[5] = 1'b1;
            q_seg.push_back(s);
            tot += w1[15:0];
            if (w1[25]) drain = 1;
            if (w1[31]) begin
                x_under = (tot < exp_len);
                x_over  = (tot > exp_len) && !drain;
                break;
            end
            if (i == MAXD - 1) begin x_chain = 1; break; end
            p = p + 8;
        end
        x_total = 32'(tot);
    endtask

    task automatic kick(input logic [31:0] ptr, input logic [31:0] exp_len);
        predict(ptr, exp_len);
        base_ptr = ptr; expect_len = exp_len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 4000; k++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic judge(input string name);
        chk(done === 1'b1, "R3", {name, " done"}, done, 1);
        chk(busy === 1'b0, "R3", {name, " busy at done"}, busy, 0);
        chk(total_bytes === x_total, "R4", {name, " total"}, total_bytes, x_total);
        chk(underflow === x_under, "R5", {name, " underflow"}, underflow, x_under);
        chk(overflow === x_over, "R6", {name, " overflow"}, overflow, x_over);
        chk(err_cdb_order === x_cmd, "R7", {name, " cmd order"}, err_cdb_order, x_cmd);
        chk(err_zero_len === x_zero, "R8", {name, " zero len"}, err_zero_len, x_zero);
        chk(err_seg_long === x_long, "R9", {name, " long seg"}, err_seg_long, x_long);
        chk(err_chain_long === x_chain, "R10", {name, " chain"}, err_chain_long, x_chain);
        chk(q_fetch.size() == 0, "R1", {name, " fetches left"}, q_fetch.size(), 0);
        chk(q_seg.size() == 0, "R2", {name, " segments left"}, q_seg.size(), 0);
    endtask

    task automatic run(input logic [31:0] ptr, input logic [31:0] exp_len, input string name);
        kick(ptr, exp_len);
        wait_done();
        judge(name);
        @(negedge clk);
    endtask

    // memory responder
    initial begin
        int cnt = 0;
        int cyc = 0;
        bit take;
        logic [31:0] held;
        forever begin
            @(negedge clk);
            take = mem_req_valid && mem_req_ready;
            held = mem[(mem_req_addr >> 2) & 255];
            @(posedge clk);
            #1;
            cyc++;
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = held_q;
                end
            end
            if (take) begin
                held_q = held;
                cnt = mem_lat;
            end
            mem_req_ready = stall ? (cyc % 3 != 0) : 1'b1;
        end
    end
    logic [31:0] held_q = '0;

    // segment consumer
    initial begin
        int cnt = 0;
        int cyc = 0;
        bit take;
        forever begin
            @(negedge clk);
            take = seg_valid && seg_ready;
            @(posedge clk);
            #1;
            cyc++;
            seg_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) seg_done = 1'b1;
            end
            if (take) cnt = seg_lat;
            seg_ready = stall ? (cyc % 2 == 0) : 1'b1;
        end
    end

    // per-clock comparison against the reference queues
    initial begin
        bit outstanding = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mem_req_valid || seg_valid) begin
                    chk(!(mem_req_valid && outstanding), "R1", "fetch during open segment",
                        mem_req_valid, 0);
                end
                if (mem_req_valid && mem_req_ready) begin
                    if (q_fetch.size() == 0) begin
                        chk(0, "R1", "unexpected fetch", mem_req_addr, 0);
                    end else begin
                        logic [31:0] e;
                        e = q_fetch.pop_front();
                        chk(mem_req_addr === e, "R1", "fetch address", mem_req_addr, e);
                    end
                end
                if (seg_valid && seg_ready) begin
                    if (q_seg.size() == 0) begin
                        chk(0, "R2", "unexpected segment", seg_addr, 0);
                    end else begin
                        seg_t e;
                        e = q_seg.pop_front();
                        chk(seg_addr === e.a, "R2", "segment address", seg_addr, e.a);
                        chk(seg_len === e.l, "R2", "segment length", seg_len, e.l);
                        chk(seg_flags === e.f, "R2", "segment flags", seg_flags, e.f);
                    end
                    outstanding = 1;
                end
                if (seg_done) outstanding = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // single end descriptor
        put_desc(32'h000, 32'h1000_0000, 16'd512, 8'h90);
        // three-entry chain
        put_desc(32'h040, 32'h2000_0000, 16'd100, 8'h30);
        put_desc(32'h048, 32'h2000_1000, 16'd200, 8'h30);
        put_desc(32'h050, 32'h2000_2000, 16'd300, 8'hB0);
        // drain
        put_desc(32'h080, 32'h3000_0000, 16'd300, 8'h12);
        put_desc(32'h088, 32'h3000_1000, 16'd300, 8'h90);
        // packet command first
        put_desc(32'h0C0, 32'h4000_0000, 16'd12, 8'h04);
        put_desc(32'h0C8, 32'h4000_1000, 16'd512, 8'h90);
        // packet command late
        put_desc(32'h100, 32'h5000_0000, 16'd64, 8'h10);
        put_desc(32'h108, 32'h5000_1000, 16'd12, 8'h04);
        // zero length second
        put_desc(32'h140, 32'h6000_0000, 16'd256, 8'h10);
        put_desc(32'h148, 32'h6000_1000, 16'd0, 8'h90);
        // largest legal, then one over
        put_desc(32'h180, 32'h7000_0000, 16'd65024, 8'h90);
        put_desc(32'h1C0, 32'h7100_0000, 16'd65025, 8'h90);
        // chain without end mark
        for (int i = 0; i < MAXD; i++)
            put_desc(32'h200 + i * 8, 32'h8000_0000 + i * 32'h100, 16'd16, 8'h10);

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(busy === 1'b0, "R12", "busy in reset", busy, 0);
        chk(done === 1'b0, "R12", "done in reset", done, 0);
        chk(mem_req_valid === 1'b0, "R12", "read req in reset", mem_req_valid, 0);
        chk(seg_valid === 1'b0, "R12", "segment in reset", seg_valid, 0);
        chk({underflow, overflow, err_zero_len, err_seg_long, err_cdb_order, err_chain_long}
            === 6'b0, "R12", "flags in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R12", "idle after reset", busy, 0);

        // R3 R4 basic
        run(32'h000, 32'd512, "single");
        // R1 R2 chain with stalls and longer latencies
        stall = 1; mem_lat = 3; seg_lat = 4;
        run(32'h040, 32'd600, "chain");
        stall = 0; mem_lat = 1; seg_lat = 1;
        // R5 underflow
        run(32'h040, 32'd1000, "short");
        // R6 overflow, then drain suppresses it
        run(32'h040, 32'd500, "excess");
        run(32'h080, 32'd500, "drain");
        // R7
        run(32'h0C0, 32'd524, "cmd first");
        run(32'h100, 32'd76, "cmd late");
        // R8
        mem_lat = 2;
        run(32'h140, 32'd256, "zero");
        // R9 edge
        run(32'h180, 32'd65024, "max seg");
        run(32'h1C0, 32'd65025, "over max");
        // R10
        seg_lat = 2;
        run(32'h200, 32'd128, "chain depth");

        // R11 start while busy is ignored
        stall = 1; seg_lat = 3;
        kick(32'h040, 32'd600);
        repeat (5) @(negedge clk);
        chk(busy === 1'b1, "R11", "busy before poke", busy, 1);
        base_ptr = 32'h300; start = 1'b1;
        @(negedge clk);
        start = 1'b0; base_ptr = 32'h040;
        wait_done();
        judge("poke R11");
        @(negedge clk);
        stall = 0; seg_lat = 1;

        // R3 restart in the done cycle
        kick(32'h000, 32'd512);
        wait_done();
        judge("first of pair");
        kick(32'h0C0, 32'd524);
        chk(done === 1'b0, "R3", "done dropped after restart", done, 0);
        chk(busy === 1'b1, "R3", "busy after restart", busy, 1);
        chk(total_bytes === 32'd0, "R4", "total cleared on start", total_bytes, 0);
        wait_done();
        judge("second of pair");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule